// File: doc/BRIEF.md
# Self-Correcting Triple-Redundant Register File

A small bank of configuration words for use behind a serial control interface. Every stored bit lives in three independent copies (lanes), and everything the block presents is the bitwise two-of-three majority of those lanes. A single upset copy therefore never reaches the read port.

A dedicated refresh input scrubs the whole bank. On a refresh edge, every word whose lanes disagree is rewritten in all three lanes from its voted value. No write-port activity is needed for this. A test input can block the scrub, so that injected upsets build up and stay visible. An injection port flips chosen bits of one lane of one word, which lets a bench prove both the masking and the repair.

The block also reports disagreement. It gives a per-word flag, a count of the words that currently disagree, and a sticky saturating tally of the words repaired by refresh.

Top module: `tmr_regfile`

## Requirements
- R1: `rd_data` is the bitwise 2-of-3 majority of the three lanes of the word at `rd_addr`, combinationally. A flip confined to one lane leaves it unchanged. The same bits flipped in two lanes invert those bits of the read value.
- R2: With `wr_en` high at a rising edge, all three lanes of word `wr_addr` take `wr_data` at that edge. All other words keep their contents.
- R3: With `rst_n` low at a rising edge (synchronous), every lane of every word clears to zero and `corr_count` clears to zero. As a result, all reads, `mismatch_flags` and `mismatch_count` show zero.
- R4: With `refresh` high and `scrub_block` low at a rising edge, every word not being written takes its voted value into all three lanes. After that edge no word flags a mismatch.
- R5: With `scrub_block` high, `refresh` has no effect: lanes, flags and counters stay as they were.
- R6: `mismatch_flags[i]` is high exactly when the lanes of word i are not all equal. `mismatch_count` is the number of such words.
- R7: On each unblocked refresh edge, `corr_count` adds the number of flagged words that are not written in that cycle. It saturates at all ones and only reset lowers it.
- R8: With `inj_en` high, and neither a write nor an unblocked refresh in the same cycle, a rising edge XORs `inj_mask` into one lane of word `wr_addr`. `inj_lane` selects the lane: 0, 1 or 2. The value 3 selects no lane.
- R9: Per word, a write takes priority over a refresh, and a refresh takes priority over an injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write and injection address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Voted read data |
| refresh | input | 1 | Scrub all words from their voted values |
| scrub_block | input | 1 | Test input that disables scrubbing |
| inj_en | input | 1 | Upset injection strobe |
| inj_lane | input | 2 | Lane to upset (3 = none) |
| inj_mask | input | DATA_W | Bits to flip |
| mismatch_flags | output | 2**ADDR_W | Per-word lane disagreement |
| mismatch_count | output | clog2(2**ADDR_W+1) | Number of disagreeing words |
| corr_count | output | CNT_W | Sticky saturating repair tally |

## Verification
A corrupt lane is invisible on `rd_data` while it stands alone, by design. At the ports it shows only through `mismatch_flags` and `mismatch_count`, in the cycle after the upset edge. It reaches the read value only when a second lane goes bad in the same bits. A faulty scrub or tally path shows one edge after a refresh: flags that stay set, or a `corr_count` that differs from the number of words that were flagged. The bench keeps a three-lane model of every word and sweeps every address, lane and mixed-priority case against it after every edge.

// File: rtl/tmr_pkg.sv
// Shared definitions for the triple-redundant register file.
// Assumes exactly three lanes; the lane code 3 selects none.
package tmr_pkg;
    localparam int LANES = 3;

    typedef enum logic [1:0] {
        LANE_A    = 2'd0,
        LANE_B    = 2'd1,
        LANE_C    = 2'd2,
        LANE_NONE = 2'd3
    } lane_t;
endpackage

// File: rtl/tmr_vote.sv
// Bitwise two-of-three majority voter with a disagreement flag.
// Assumes all inputs share the width W; purely combinational.
module tmr_vote #(
    parameter int W = 8
) (
    input  logic [W-1:0] lane_a,
    input  logic [W-1:0] lane_b,
    input  logic [W-1:0] lane_c,
    output logic [W-1:0] voted,
    output logic         differ
);
    // Majority per bit, and any-lane-differs detection.
    always_comb begin
        voted  = (lane_a & lane_b) | (lane_a & lane_c) | (lane_b & lane_c);
        differ = (lane_a != lane_b) || (lane_a != lane_c);
    end
endmodule

// File: rtl/tmr_word.sv
// One configuration word held in three lanes, read through a voter.
// Assumes the caller decodes the address into wr_hit and inj_hit.
// Priority per edge is reset, write, scrub, injection.
module tmr_word
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         scrub_go,
    input  logic         inj_hit,
    input  lane_t        inj_lane,
    input  logic [W-1:0] inj_mask,
    output logic [W-1:0] voted,
    output logic         mismatch
);
    logic [W-1:0] lane_w [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [W-1:0] q;

        // Lane storage: clear, write, scrub from vote, or take an upset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_hit)
                q <= wr_data;
            else if (scrub_go)
                q <= voted;
            else if (inj_hit && inj_lane == lane_t'(l))
                q <= q ^ inj_mask;
        end

        assign lane_w[l] = q;
    end

    tmr_vote #(.W(W)) u_vote (
        .lane_a (lane_w[0]),
        .lane_b (lane_w[1]),
        .lane_c (lane_w[2]),
        .voted  (voted),
        .differ (mismatch)
    );

    p_write_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (lane_w[0] == $past(wr_data) && lane_w[1] == $past(wr_data)
                    && lane_w[2] == $past(wr_data)));

    p_scrub_repairs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_go |=> !mismatch);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !scrub_go && !inj_hit) |=>
        ($stable(lane_w[0]) && $stable(lane_w[1]) && $stable(lane_w[2])));

    p_single_flip_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_hit && !wr_hit && !scrub_go && !mismatch) |=> $stable(voted));
endmodule

// File: rtl/tmr_scrub_tally.sv
// Counts disagreeing words and keeps a sticky saturating tally of
// words repaired by scrubbing. A word written in the scrub cycle is
// repaired by the write and is not tallied.
module tmr_scrub_tally #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int NW    = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scrub_go,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DEPTH-1:0] flags,
    output logic [NW-1:0]    mismatch_count,
    output logic [CNT_W-1:0] corr_count
);
    localparam int SUM_W   = ((CNT_W > NW) ? CNT_W : NW) + 1;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((64'd1 << CNT_W) - 64'd1);

    logic [NW-1:0]    fixed_n;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] corr_q;

    // Population counts of flagged words and of words the scrub repairs.
    always_comb begin
        mismatch_count = '0;
        fixed_n        = '0;
        for (int i = 0; i < DEPTH; i++) begin
            mismatch_count = mismatch_count + NW'(flags[i]);
            if (flags[i] && scrub_go && !(wr_en && wr_addr == AW'(i)))
                fixed_n = fixed_n + NW'(1);
        end
        sum = SUM_W'(corr_q) + SUM_W'(fixed_n);
    end

    // Sticky tally with saturation at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corr_q <= '0;
        else if (scrub_go)
            corr_q <= (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
    end

    assign corr_count = corr_q;

    p_count_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> corr_q >= $past(corr_q));

    p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !scrub_go |=> $stable(corr_q));
endmodule

// File: rtl/tmr_regfile.sv
// Triple-redundant configuration register file with refresh scrub.
// Assumes one write or injection per cycle, addressed by wr_addr;
// reads are combinational through each word's voter.
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [DATA_W-1:0]                    rd_data,
    input  logic                                 refresh,
    input  logic                                 scrub_block,
    input  logic                                 inj_en,
    input  logic [1:0]                           inj_lane,
    input  logic [DATA_W-1:0]                    inj_mask,
    output logic [(1<<ADDR_W)-1:0]               mismatch_flags,
    output logic [$clog2((1<<ADDR_W)+1)-1:0]     mismatch_count,
    output logic [CNT_W-1:0]                     corr_count
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NW    = $clog2(DEPTH + 1);

    logic              scrub_go;
    logic [DATA_W-1:0] voted_w [DEPTH];

    // Scrub is enabled only when the test block is released.
    always_comb scrub_go = refresh && !scrub_block;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic hit;

        // Address decode for this word.
        always_comb hit = (wr_addr == ADDR_W'(i));

        tmr_word #(.W(DATA_W)) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_en && hit),
            .wr_data  (wr_data),
            .scrub_go (scrub_go),
            .inj_hit  (inj_en && hit),
            .inj_lane (lane_t'(inj_lane)),
            .inj_mask (inj_mask),
            .voted    (voted_w[i]),
            .mismatch (mismatch_flags[i])
        );
    end

    // Read multiplexer over the voted words.
    always_comb rd_data = voted_w[rd_addr];

    tmr_scrub_tally #(
        .DEPTH (DEPTH),
        .AW    (ADDR_W),
        .NW    (NW),
        .CNT_W (CNT_W)
    ) u_tally (
        .clk            (clk),
        .rst_n          (rst_n),
        .scrub_go       (scrub_go),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .flags          (mismatch_flags),
        .mismatch_count (mismatch_count),
        .corr_count     (corr_count)
    );

    p_block_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && scrub_block && !wr_en && !inj_en) |=> $stable(mismatch_flags));

    p_clean_after_scrub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_go && !inj_en) |=> mismatch_count == '0);
endmodule

// File: tb/tmr_regfile_test.sv
// Bench: three-lane model of every word, swept after every edge.
module tmr_regfile_test;
    localparam int AW = 3, DW = 8, CW = 6, DEPTH = 8, CMAX = 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, refresh = 1'b0, scrub_block = 1'b0, inj_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, inj_mask = '0, rd_data;
    logic [1:0] inj_lane = 2'd3;
    logic [DEPTH-1:0] mismatch_flags;
    logic [3:0] mismatch_count;
    logic [CW-1:0] corr_count;

    int checks = 0, fails = 0, corr_exp = 0;
    bit done = 0;
    logic [DW-1:0] m [DEPTH][3];

    always #4 clk = ~clk;

    tmr_regfile #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .refresh(refresh), .scrub_block(scrub_block), .inj_en(inj_en),
        .inj_lane(inj_lane), .inj_mask(inj_mask),
        .mismatch_flags(mismatch_flags), .mismatch_count(mismatch_count),
        .corr_count(corr_count)
    );

    function automatic logic [DW-1:0] vote(int a);
        return (m[a][0] & m[a][1]) | (m[a][0] & m[a][2]) | (m[a][1] & m[a][2]);
    endfunction

    function automatic bit differs(int a);
        return (m[a][0] != m[a][1]) || (m[a][0] != m[a][2]);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Sweep every address and the status outputs against the model.
    task automatic verify(string tag);
        int nbad = 0;
        logic [DEPTH-1:0] fexp = '0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            chk(tag, "rd_data", int'(rd_data), int'(vote(a)));
            fexp[a] = differs(a);
            if (differs(a)) nbad++;
        end
        chk(tag, "mismatch_flags", int'(mismatch_flags), int'(fexp));
        chk("R6", "mismatch_count", int'(mismatch_count), nbad);
        chk(tag, "corr_count", int'(corr_count), corr_exp);
    endtask

    // One clock with the given controls; model follows R2, R4, R7, R8, R9.
    task automatic step(bit wr, int addr, logic [DW-1:0] d, bit rf, bit blk,
                        bit inj, int lane, logic [DW-1:0] mask);
        logic [DW-1:0] v;
        bit go;
        @(negedge clk);
        wr_en = wr; wr_addr = AW'(addr); wr_data = d; refresh = rf;
        scrub_block = blk; inj_en = inj; inj_lane = 2'(lane); inj_mask = mask;
        go = rf && !blk;
        for (int a = 0; a < DEPTH; a++) begin
            if (wr && a == addr) begin
                for (int l = 0; l < 3; l++) m[a][l] = d;
            end else if (go) begin
                if (differs(a)) corr_exp = (corr_exp < CMAX) ? corr_exp + 1 : CMAX;
                v = vote(a);
                for (int l = 0; l < 3; l++) m[a][l] = v;
            end else if (inj && a == addr && lane < 3) begin
                m[a][lane] = m[a][lane] ^ mask;
            end
        end
        @(posedge clk);
        #1;
        wr_en = 0; refresh = 0; scrub_block = 0; inj_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        for (int a = 0; a < DEPTH; a++)
            for (int l = 0; l < 3; l++) m[a][l] = '0;
        corr_exp = 0;
        @(posedge clk);
        #1;
        rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++)
            for (int l = 0; l < 3; l++) m[a][l] = '0;
        // R3: reset state, including after scribbled writes
        step(1, 2, 8'hAA, 0, 0, 0, 3, 8'h00);
        do_reset();
        verify("R3");

        // R2: fill every word with a computed pattern
        for (int a = 0; a < DEPTH; a++) begin
            step(1, a, DW'(a * 37 + 5), 0, 0, 0, 3, 8'h00);
            verify("R2");
        end

        // R1, R5, R4: every word, every lane, single flip
        for (int a = 0; a < DEPTH; a++)
            for (int l = 0; l < 3; l++) begin
                step(0, a, 8'h00, 0, 0, 1, l, DW'(1 << ((a + l) % DW)));
                verify("R1");
                step(0, 0, 8'h00, 1, 1, 0, 3, 8'h00);
                verify("R5");
                step(0, 0, 8'h00, 1, 0, 0, 3, 8'h00);
                verify("R4");
            end

        // R1: same bits in two lanes overturn the vote
        step(0, 3, 8'h00, 0, 0, 1, 0, 8'hF0);
        step(0, 3, 8'h00, 0, 0, 1, 1, 8'hF0);
        verify("R1");
        // R8: lane code 3 touches nothing
        step(0, 3, 8'h00, 0, 0, 1, 3, 8'hFF);
        verify("R8");
        step(0, 0, 8'h00, 1, 0, 0, 3, 8'h00);
        verify("R4");

        // R9: write beats refresh (not tallied), write beats injection
        step(0, 5, 8'h00, 0, 0, 1, 2, 8'h0F);
        step(0, 1, 8'h00, 0, 0, 1, 0, 8'h01);
        step(1, 5, 8'h3C, 1, 0, 0, 3, 8'h00);
        verify("R9");
        step(1, 6, 8'h11, 0, 0, 1, 0, 8'hFF);
        verify("R9");

        // R7: drive the tally into saturation
        for (int r = 0; r < 6; r++) begin
            for (int a = 0; a < DEPTH; a++)
                step(0, a, 8'h00, 0, 0, 1, r % 3, 8'h81);
            step(0, 0, 8'h00, 1, 0, 0, 3, 8'h00);
            verify("R7");
        end

        // R3: reset in mid-run clears flips and tally
        step(0, 4, 8'h00, 0, 0, 1, 1, 8'h55);
        do_reset();
        verify("R3");

        done = 1;
        summary();
    end
endmodule